// File: doc/BRIEF.md
# ADC Conversion Control Sequencer

This block is the digital side of an analog-to-digital converter. Software controls it through one 8-bit mode register. Writing a 1 to the start bit begins a run. The run is either one conversion or a repeating series. It converts either one channel picked by a separate input, or all four channels in turn.

The block asks the analog converter for each sample with a one-cycle request carrying a 2-bit channel number. It waits for the converter's done pulse, then stores the 10-bit sample in one of four result slots. The slots can be read at any time through a slot-select input.

Two status bits sit in the mode register: a busy flag and an end-of-conversion flag. The end-of-conversion flag clears when the register is read. An interrupt line gives a one-cycle pulse whenever the end-of-conversion flag is set. In repeating fixed-channel runs, one control bit chooses between an interrupt after every sample and an interrupt after every group of four.

Top module: `adc_conv_sequencer`

## Requirements
- R1: After reset the mode register reads 0x00, and both the interrupt output and the converter request are low.
- R2: Mode register bits 3 (interrupt interval), 2 (repeat mode) and 1 (scan mode) hold the values written to them. Bits 0, 4 and 5 always read 0. Bit 7 is the end-of-conversion flag and bit 6 is the busy flag; writes do not change either of them.
- R3: A write with bit 0 set while busy is 0 makes busy read 1 in the next cycle, and the converter request is high for exactly that one cycle. A write with bit 0 clear starts nothing.
- R4: In a single fixed-channel run (bits 2 and 1 both 0):
  - the converter is asked for the channel on the fixed-channel input;
  - the sample goes to slot 0;
  - in the cycle after the done pulse, busy reads 0, the end-of-conversion flag reads 1 and the interrupt pulses.
- R5: In a scan run (bit 1 set), channels 0, 1, 2 and 3 are converted in that order, and each sample is stored in the slot with the same number. The interrupt and the end-of-conversion flag come only after channel 3.
- R6: In a repeating fixed-channel run with bit 3 at 0:
  - samples go to slots 0, 1, 2, 3, 0, … in rotation;
  - every sample raises the interrupt.
- R7: In a repeating fixed-channel run with bit 3 at 1, the interrupt is raised only for the sample stored in slot 3.
- R8: A read strobe clears the end-of-conversion flag from the next cycle on. The data read in the strobe cycle shows the flag's value from before the read. If a new flag set lands in the same cycle as the read, the set wins.
- R9: A start request written while busy reads 1 is ignored. No extra request is issued, and the run in progress is not disturbed.
- R10: Clearing bit 2 during a run stops the run without cutting anything short:
  - a fixed-channel run ends after the conversion in progress, and that last sample raises the interrupt;
  - a scan run first completes its pass up to channel 3, then stops.
- R11: The interrupt output is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Mode register write strobe |
| regWrData | input | 8 | Mode register write data |
| regRdEn | input | 1 | Mode register read strobe; clears the end-of-conversion flag |
| regRdData | output | 8 | Mode register read value |
| fixedChan | input | 2 | Channel used in fixed-channel runs |
| convReq | output | 1 | One-cycle request to the analog converter |
| convChan | output | 2 | Channel for the current request |
| convDone | input | 1 | Converter done pulse |
| convData | input | 10 | Converter sample, valid with convDone |
| slotSel | input | 2 | Result slot select |
| slotData | output | 10 | Contents of the selected slot |
| irqPulse | output | 1 | One-cycle interrupt pulse |

## Verification
The effect of a mode write shows in the next cycle: busy and the converter request both rise one cycle after the write strobe. The effect of a done pulse also shows in the next cycle: the slot contents, the interrupt, the end-of-conversion flag and the drop of busy all appear one cycle after the done pulse. The flag clear from a read strobe appears one cycle after the strobe. The bench's scoreboard pairs each request with an expected channel, slot, interrupt and end-of-run item, and checks the request's channel in the request cycle. It samples the slot, the interrupt and the flags exactly one cycle after the done pulse it produces itself. On every other cycle it flags any interrupt pulse as unexpected.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int NUM_SLOTS = 4;
  localparam int SLOT_W = $clog2(NUM_SLOTS);
  localparam int REG_W = 8;

  // mode register bit positions
  localparam int BIT_START = 0;
  localparam int BIT_SCAN = 1;
  localparam int BIT_REPEAT = 2;
  localparam int BIT_GROUP = 3;
  localparam int BIT_BUSY = 6;
  localparam int BIT_EOC = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ = 2'd1,
    ST_WAIT = 2'd2
  } seq_state_t;

  typedef struct packed {
    logic storeEn;
    logic [SLOT_W-1:0] slotIdx;
    logic setEoc;
  } seq_strobe_t;
endpackage

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              startWr,
  input  logic              startScan,
  input  logic              repeatMode,
  input  logic              groupIrq,
  input  logic [SLOT_W-1:0] fixedChan,
  input  logic              convDone,
  output logic              convReq,
  output logic [SLOT_W-1:0] convChan,
  output logic              busy,
  output seq_strobe_t       strb
);
  seq_state_t state;
  logic [SLOT_W-1:0] chanIdx;
  logic scanRun;
  logic lastSlot;
  logic fire;
  logic doneHere;
  logic keepGoing;

  assign lastSlot = (chanIdx == SLOT_W'(NUM_SLOTS - 1));
  assign doneHere = (state == ST_WAIT) && convDone;
  // a scan pass always completes; otherwise the repeat bit decides
  assign keepGoing = (scanRun && !lastSlot) || repeatMode;
  assign fire = scanRun ? lastSlot : (!groupIrq || !repeatMode || lastSlot);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      chanIdx <= '0;
      scanRun <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startWr) begin
            state <= ST_REQ;
            chanIdx <= '0;
            scanRun <= startScan;
          end
        end
        ST_REQ: state <= ST_WAIT;
        ST_WAIT: begin
          if (convDone) begin
            if (keepGoing) begin
              state <= ST_REQ;
              chanIdx <= chanIdx + SLOT_W'(1);
            end else begin
              state <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    convReq = (state == ST_REQ);
    convChan = scanRun ? chanIdx : fixedChan;
    busy = (state != ST_IDLE);
    strb.storeEn = doneHere;
    strb.slotIdx = chanIdx;
    strb.setEoc = doneHere && fire;
  end
endmodule

// File: rtl/adc_seq_datapath.sv
module adc_seq_datapath
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [3:1]        modeWrBits,
  input  logic              regRdEn,
  input  logic              busy,
  input  seq_strobe_t       strb,
  input  logic [DATA_W-1:0] convData,
  input  logic [SLOT_W-1:0] slotSel,
  output logic [REG_W-1:0]  regRdData,
  output logic [DATA_W-1:0] slotData,
  output logic              irqPulse,
  output logic              repeatMode,
  output logic              groupIrq
);
  logic scanMode;
  logic eocFlag;
  logic [DATA_W-1:0] resReg [NUM_SLOTS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      scanMode <= 1'b0;
      repeatMode <= 1'b0;
      groupIrq <= 1'b0;
    end else if (regWrEn) begin
      scanMode <= modeWrBits[BIT_SCAN];
      repeatMode <= modeWrBits[BIT_REPEAT];
      groupIrq <= modeWrBits[BIT_GROUP];
    end
  end

  // a completion in the read cycle must not be lost: set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      eocFlag <= 1'b0;
      irqPulse <= 1'b0;
    end else begin
      if (strb.setEoc) eocFlag <= 1'b1;
      else if (regRdEn) eocFlag <= 1'b0;
      irqPulse <= strb.setEoc;
    end
  end

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) resReg[g] <= '0;
      else if (strb.storeEn && (strb.slotIdx == SLOT_W'(g))) resReg[g] <= convData;
    end
  end

  always_comb begin
    regRdData = '0;
    regRdData[BIT_EOC] = eocFlag;
    regRdData[BIT_BUSY] = busy;
    regRdData[BIT_GROUP] = groupIrq;
    regRdData[BIT_REPEAT] = repeatMode;
    regRdData[BIT_SCAN] = scanMode;
    slotData = resReg[slotSel];
  end
endmodule

// File: rtl/adc_conv_sequencer.sv
module adc_conv_sequencer
  import adc_seq_pkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [7:0]        regWrData,
  input  logic              regRdEn,
  output logic [7:0]        regRdData,
  input  logic [1:0]        fixedChan,
  output logic              convReq,
  output logic [1:0]        convChan,
  input  logic              convDone,
  input  logic [DATA_W-1:0] convData,
  input  logic [1:0]        slotSel,
  output logic [DATA_W-1:0] slotData,
  output logic              irqPulse
);
  seq_strobe_t strb;
  logic busy;
  logic repeatMode;
  logic groupIrq;
  logic startWr;
  logic unusedWrBits;

  assign startWr = regWrEn && regWrData[BIT_START];
  // status and reserved bits are not writable
  assign unusedWrBits = ^regWrData[7:4];

  adc_seq_ctrl uCtrl (
    .clk(clk),
    .rstN(rstN),
    .startWr(startWr),
    .startScan(regWrData[BIT_SCAN]),
    .repeatMode(repeatMode),
    .groupIrq(groupIrq),
    .fixedChan(fixedChan),
    .convDone(convDone),
    .convReq(convReq),
    .convChan(convChan),
    .busy(busy),
    .strb(strb)
  );

  adc_seq_datapath #(.DATA_W(DATA_W)) uPath (
    .clk(clk),
    .rstN(rstN),
    .regWrEn(regWrEn),
    .modeWrBits(regWrData[3:1]),
    .regRdEn(regRdEn),
    .busy(busy),
    .strb(strb),
    .convData(convData),
    .slotSel(slotSel),
    .regRdData(regRdData),
    .slotData(slotData),
    .irqPulse(irqPulse),
    .repeatMode(repeatMode),
    .groupIrq(groupIrq)
  );
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker (
  input logic       clk,
  input logic       rstN,
  input logic       regWrEn,
  input logic [7:0] regWrData,
  input logic       regRdEn,
  input logic [7:0] regRdData,
  input logic       convReq,
  input logic       convDone,
  input logic       irqPulse
);
  p_fixed_zero_bits_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[0] == 1'b0) && (regRdData[5:4] == 2'b00));

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regWrData[0] && !regRdData[6]) |=> (regRdData[6] && convReq));

  p_req_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    convReq |=> !convReq);

  p_req_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    convReq |-> regRdData[6]);

  p_eoc_read_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> (!regRdData[7] || irqPulse));

  p_eoc_with_irq_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(regRdData[7]) |-> irqPulse);

  p_busy_start_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdData[6] && !convReq && !convDone && regWrEn && regWrData[0]) |=> !convReq);

  p_irq_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    irqPulse |=> !irqPulse);
endmodule

bind adc_conv_sequencer adc_seq_checker uChk (
  .clk(clk),
  .rstN(rstN),
  .regWrEn(regWrEn),
  .regWrData(regWrData),
  .regRdEn(regRdEn),
  .regRdData(regRdData),
  .convReq(convReq),
  .convDone(convDone),
  .irqPulse(irqPulse)
);

// File: tb/tb_adc_conv_sequencer.sv
module tb_adc_conv_sequencer;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 3;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic regRdEn = 1'b0;
  logic [7:0] regRdData;
  logic [1:0] fixedChan = '0;
  logic convReq;
  logic [1:0] convChan;
  logic convDone = 1'b0;
  logic [9:0] convData = '0;
  logic [1:0] slotSel = '0;
  logic [9:0] slotData;
  logic irqPulse;

  typedef struct {
    logic [1:0] chan;
    logic [1:0] slot;
    bit irq;
    bit last;
  } exp_t;

  exp_t expQ[$];
  exp_t curItem;
  exp_t pend;
  logic [9:0] pendData;
  bit chkPending = 0;
  int latCnt = 0;
  logic [1:0] reqChan = '0;
  logic [7:0] dataSeq = 8'h5a;
  int reqCount = 0;
  int nChecks = 0;
  int nFails = 0;
  logic [7:0] rd;

  adc_conv_sequencer dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdEn(regRdEn), .regRdData(regRdData), .fixedChan(fixedChan),
    .convReq(convReq), .convChan(convChan), .convDone(convDone),
    .convData(convData), .slotSel(slotSel), .slotData(slotData),
    .irqPulse(irqPulse)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic writeMode(input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    regWrData = '0;
  endtask

  task automatic readMode(output logic [7:0] v);
    @(negedge clk);
    regRdEn = 1'b1;
    #1 v = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic pushItem(input logic [1:0] c, input logic [1:0] s, input bit i, input bit l);
    exp_t e;
    e.chan = c; e.slot = s; e.irq = i; e.last = l;
    expQ.push_back(e);
  endtask

  // start a run and check the R3 timing of busy and request
  task automatic startRun(input logic [7:0] d);
    writeMode(d);
    #2;
    check(regRdData[6] == 1'b1, "R3 busy after start", regRdData[6], 1);
    check(convReq == 1'b1, "R3 request after start", convReq, 1);
  endtask

  task automatic waitIdle();
    do begin
      @(negedge clk);
      #2;
    end while (regRdData[6] || expQ.size() != 0 || chkPending);
  endtask

  task automatic waitReq(input int n);
    while (reqCount < n) @(negedge clk);
    #2;
  endtask

  // converter model and scoreboard monitor in one process
  initial begin
    forever begin
      @(negedge clk);
      convDone = 1'b0;
      if (latCnt != 0) begin
        latCnt--;
        if (latCnt == 0) begin
          convDone = 1'b1;
          convData = {reqChan, dataSeq};
          dataSeq = dataSeq + 8'd37;
        end
      end
      if (convReq) begin
        reqChan = convChan;
        latCnt = LAT;
        reqCount++;
        if (expQ.size() == 0) begin
          check(1'b0, "R9 unexpected request", 1, 0);
        end else begin
          curItem = expQ.pop_front();
          check(convChan == curItem.chan, "R4/R5 request channel", convChan, curItem.chan);
        end
      end
      if (chkPending) begin
        slotSel = pend.slot;
        #1;
        check(slotData == pendData, "R4/R5/R6 slot contents", slotData, pendData);
        check(irqPulse == pend.irq, "R6/R7 interrupt", irqPulse, pend.irq);
        check(regRdData[6] == !pend.last, "R10 busy after sample", regRdData[6], !pend.last);
        if (pend.irq) check(regRdData[7] == 1'b1, "R4 end-of-conversion flag", regRdData[7], 1);
        chkPending = 0;
      end else begin
        #1;
        if (irqPulse) check(1'b0, "R11 unexpected interrupt", 1, 0);
      end
      if (convDone) begin
        chkPending = 1;
        pend = curItem;
        pendData = convData;
      end
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #2;
    // R1
    check(regRdData == 8'h00, "R1 mode after reset", regRdData, 0);
    check(irqPulse == 1'b0, "R1 interrupt after reset", irqPulse, 0);
    check(convReq == 1'b0, "R1 request after reset", convReq, 0);

    // R2 / R3: writable bits, zero bits, no start
    writeMode(8'hFE);
    readMode(rd);
    check(rd == 8'h0E, "R2 mode readback", rd, 8'h0E);
    repeat (5) @(negedge clk);
    check(reqCount == 0, "R3 no start with bit 0 clear", reqCount, 0);
    writeMode(8'h00);
    readMode(rd);
    check(rd == 8'h00, "R2 mode cleared", rd, 0);

    // R4 single fixed channel
    fixedChan = 2'd2;
    pushItem(2'd2, 2'd0, 1, 1);
    startRun(8'h01);
    waitIdle();
    readMode(rd);
    check(rd == 8'h80, "R8 flag seen by read", rd, 8'h80);
    readMode(rd);
    check(rd == 8'h00, "R8 flag cleared by read", rd, 0);

    // R5 scan single
    for (int k = 0; k < 4; k++) pushItem(2'(k), 2'(k), k == 3, k == 3);
    startRun(8'h03);
    waitIdle();
    readMode(rd);
    check(rd == 8'h82, "R5 flag after scan", rd, 8'h82);
    readMode(rd);
    check(rd == 8'h02, "R8 cleared after scan", rd, 8'h02);

    // R6 fixed repeat, interrupt per sample; R9 start while busy
    fixedChan = 2'd1;
    for (int k = 0; k < 6; k++) pushItem(2'd1, 2'(k % 4), 1, k == 5);
    startRun(8'h05);
    waitReq(reqCount + 1);
    writeMode(8'h05);
    waitReq(6 + 5);
    writeMode(8'h00);
    waitIdle();
    check(reqCount == 11, "R9 request count", reqCount, 11);
    readMode(rd);
    check(rd == 8'h80, "R6 flag after repeat", rd, 8'h80);

    // R7 fixed repeat, interrupt per group of four
    fixedChan = 2'd3;
    for (int k = 0; k < 8; k++) pushItem(2'd3, 2'(k % 4), (k % 4) == 3, k == 7);
    startRun(8'h0D);
    waitReq(11 + 8);
    writeMode(8'h08);
    waitIdle();

    // R10 fixed repeat stopped mid-group still interrupts
    fixedChan = 2'd0;
    pushItem(2'd0, 2'd0, 0, 0);
    pushItem(2'd0, 2'd1, 1, 1);
    startRun(8'h0D);
    waitReq(19 + 2);
    writeMode(8'h08);
    waitIdle();

    // R10 scan repeat stopped mid-pass finishes the pass
    for (int k = 0; k < 8; k++) pushItem(2'(k % 4), 2'(k % 4), (k % 4) == 3, k == 7);
    startRun(8'h07);
    waitReq(21 + 6);
    writeMode(8'h02);
    waitIdle();
    check(reqCount == 29, "R10 scan pass completed", reqCount, 29);
    readMode(rd);
    check(rd == 8'h82, "R10 final mode", rd, 8'h82);

    repeat (4) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule